// File: doc/BRIEF.md
# Serial-Bus DAC Code Register Front End

This block is the two-wire serial slave that sits in front of an 8-bit DAC code register in a calibration device. A host reaches it with a single fixed 6-bit device address. The bit that follows the address is not part of the address. In a write it supplies the least significant bit of the new code, and in a read it is ignored. The last bit of the first byte selects read or write. A read returns the live register value. A write carries the remaining seven code bits and a mode flag in its second byte. The mode flag selects between loading the register and raising a one-cycle request that the current code be stored in nonvolatile memory.

A write-protect input gates every change. With protect low, writes are still acknowledged on the bus, but neither the register nor the store request is affected. Reads work at either protect level. The bus lines arrive unsynchronized and are oversampled by the system clock. The slave pulls SDA low through an open-drain enable.

Top module: `dacif_i2c_top`

## Requirements
- R1: After reset, `dac_code` equals the parameter `INIT_CODE` (default 0x80), `sda_oe` is 0 and `prog_req` is 0.
- R2: A first byte whose bits 7..2 equal 100111 is acknowledged (SDA held low during the ninth clock). Any other value is not acknowledged, and SDA stays released for the rest of that transaction until the next START.
- R3: With write-protect high, first-byte bit 0 = 0 and second-byte bit 0 = 1, the register becomes {second byte bits 7..1, first byte bit 1}. This happens only after the second byte has been acknowledged.
- R4: With write-protect high, first-byte bit 0 = 0 and second-byte bit 0 = 0, `prog_req` pulses high for exactly one cycle and the register keeps its value.
- R5: With write-protect low, a write still has both bytes acknowledged, but the register does not change and `prog_req` stays 0.
- R6: With first-byte bit 0 = 1, the slave returns the register value MSB first at either write-protect level. First-byte bit 1 has no effect on a read.
- R7: During a read, a master ACK makes the slave send the register value again in the next byte. A master NACK makes it release SDA until the next START.
- R8: In a write, bytes after the second are not acknowledged and have no effect.
- R9: A repeated START at any point restarts address decoding.
- R10: `prog_req` is never high on two consecutive cycles, and a cycle with `prog_req` high never also changes `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the pad, asynchronous |
| wp_in | input | 1 | Write-protect; high allows register and store changes |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| dac_code | output | 8 | Current DAC code |
| prog_req | output | 1 | One-cycle request to store the current code |

## Verification
A corrupt bit counter or link state shows up within one byte. The acknowledge lands a bit early or late, or goes missing, and the host's ACK sample sees it on the ninth clock of that same byte. A wrong capture of the LSB or the mode bit shows up at the next read-back, as a wrong code or as an unexpected store pulse. Protect gating faults are visible immediately after the second byte, on `dac_code` or `prog_req`. A released-line fault after a NACK or a mismatch shows as a pulled-low SDA on the host's next sample.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_TX,
    LK_TXACK,
    LK_RX,
    LK_RXACK,
    LK_SKIP
  } link_state_t;
endpackage

// File: rtl/dacif_line_sync.sv
module dacif_line_sync #(
  parameter int          LINES   = 3,
  parameter int          STAGES  = 2,
  parameter logic [LINES-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[i]}};
        else     chain <= {chain[STAGES-2:0], raw[i]};
      end
      assign synced[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dacif_link_fsm.sv
module dacif_link_fsm
  import dacif_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b100111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic [DATA_W-1:0] code,
  output logic              sda_oe,
  output link_state_t       state,
  output logic              commit,
  output logic [DATA_W-1:0] commit_data,
  output logic              commit_mode
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic scl_d, sda_d;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] tx;
  logic y_bit, rw_bit, m_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= LK_IDLE;
      cnt         <= '0;
      sh          <= '0;
      tx          <= '0;
      y_bit       <= 1'b0;
      rw_bit      <= 1'b0;
      m_ack       <= 1'b0;
      sda_oe      <= 1'b0;
      commit      <= 1'b0;
      commit_data <= '0;
      commit_mode <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_ev) begin
        state  <= LK_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          LK_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_q};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              if (sh[DATA_W-1 -: ADDR_W] == DEV_ADDR) begin
                state  <= LK_AACK;
                sda_oe <= 1'b1;
                y_bit  <= sh[1];
                rw_bit <= sh[0];
              end else begin
                state <= LK_SKIP;
              end
            end
          end
          LK_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_bit) begin
                state  <= LK_TX;
                tx     <= code;
                sda_oe <= ~code[DATA_W-1];
              end else begin
                state  <= LK_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                state  <= LK_TXACK;
              end else begin
                cnt    <= cnt + 1'b1;
                sda_oe <= ~tx[DATA_W-2];
                tx     <= {tx[DATA_W-2:0], 1'b0};
              end
            end
          end
          LK_TXACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (m_ack) begin
                state  <= LK_TX;
                tx     <= code;
                sda_oe <= ~code[DATA_W-1];
              end else begin
                state <= LK_SKIP;
              end
            end
          end
          LK_RX: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_q};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              sda_oe <= 1'b1;
              state  <= LK_RXACK;
            end
          end
          LK_RXACK: begin
            if (scl_fall) begin
              sda_oe      <= 1'b0;
              commit      <= 1'b1;
              commit_data <= {sh[DATA_W-1:1], y_bit};
              commit_mode <= sh[0];
              state       <= LK_SKIP;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dacif_code_store.sv
module dacif_code_store #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] INIT_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [DATA_W-1:0] commit_data,
  input  logic              commit_mode,
  input  logic              wp_q,
  output logic [DATA_W-1:0] code,
  output logic              prog_req
);
  logic allow;
  assign allow = commit & wp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= INIT_CODE;
      prog_req <= 1'b0;
    end else begin
      prog_req <= allow & ~commit_mode;
      if (allow & commit_mode) code <= commit_data;
    end
  end
endmodule

// File: rtl/dacif_i2c_top.sv
module dacif_i2c_top
  import dacif_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR  = 6'b100111,
  parameter logic [DATA_W-1:0] INIT_CODE = 8'h80,
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              wp_in,
  output logic              sda_oe,
  output logic [DATA_W-1:0] dac_code,
  output logic              prog_req
);
  logic [2:0] raw_l, sync_l;
  logic scl_s, sda_s, wp_s;
  link_state_t link_state;
  logic commit, commit_mode;
  logic [DATA_W-1:0] commit_data;

  assign raw_l = {wp_in, sda_in, scl_in};
  assign scl_s = sync_l[0];
  assign sda_s = sync_l[1];
  assign wp_s  = sync_l[2];

  dacif_line_sync #(.LINES(3), .STAGES(SYNC_STG), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst), .raw(raw_l), .synced(sync_l)
  );

  dacif_link_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst(rst), .scl_q(scl_s), .sda_q(sda_s), .code(dac_code),
    .sda_oe(sda_oe), .state(link_state), .commit(commit),
    .commit_data(commit_data), .commit_mode(commit_mode)
  );

  dacif_code_store #(.DATA_W(DATA_W), .INIT_CODE(INIT_CODE)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .commit_data(commit_data),
    .commit_mode(commit_mode), .wp_q(wp_s), .code(dac_code), .prog_req(prog_req)
  );
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker
  import dacif_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] INIT_CODE = 8'h80
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic [DATA_W-1:0] dac_code,
  input logic              prog_req,
  input logic              wp_q,
  input link_state_t       st
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_code == INIT_CODE && !sda_oe && !prog_req));

  assert_released_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (st == LK_SKIP || st == LK_IDLE) |-> !sda_oe);

  assert_store_keeps_code_R4: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> $stable(dac_code));

  assert_protect_code_R5: assert property (@(posedge clk) disable iff (rst)
    !wp_q |=> $stable(dac_code));

  assert_protect_prog_R5: assert property (@(posedge clk) disable iff (rst)
    !wp_q |=> !prog_req);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);
endmodule

bind dacif_i2c_top dacif_checker #(.DATA_W(DATA_W), .INIT_CODE(INIT_CODE)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .dac_code(dac_code),
  .prog_req(prog_req), .wp_q(wp_s), .st(link_state)
);

// File: tb/dacif_i2c_top_tb_top.sv
`timescale 1ns/1ps
module dacif_i2c_top_tb_top;
  localparam int QP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b1;
  logic sda_oe, prog_req;
  logic [7:0] dac_code;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  int prog_cnt = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_oe ? 1'b0 : m_sda;

  dacif_i2c_top dut_i (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .wp_in(wp),
    .sda_oe(sda_oe), .dac_code(dac_code), .prog_req(prog_req)
  );

  always @(posedge clk) if (!rst && prog_req) prog_cnt <= prog_cnt + 1;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(QP);
    m_scl = 1'b1; tick(2*QP);
    m_sda = 1'b0; tick(2*QP);
    m_scl = 1'b0; tick(QP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(QP);
    m_scl = 1'b1; tick(2*QP);
    m_sda = 1'b1; tick(2*QP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(QP);
      m_scl = 1'b1; tick(2*QP);
      m_scl = 1'b0; tick(QP);
    end
    m_sda = 1'b1; tick(QP);
    m_scl = 1'b1; tick(QP);
    ack = ~sda_line; tick(QP);
    m_scl = 1'b0; tick(QP);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v);
    m_sda = 1'b1;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      tick(QP);
      m_scl = 1'b1; tick(QP);
      v = {v[6:0], sda_line}; tick(QP);
      m_scl = 1'b0; tick(QP);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; tick(QP);
    m_scl = 1'b1; tick(2*QP);
    m_scl = 1'b0; tick(QP);
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                          output logic ack1, output logic ack2);
    bus_start();
    send_byte(a, ack1);
    send_byte(d, ack2);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, output logic ack, output logic [7:0] v);
    bus_start();
    send_byte(a, ack);
    read_byte(1'b0, v);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 code", dac_code, 8'h80);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 prog_req", prog_req, 0);
  endtask

  task automatic t_write_basic();
    logic a1, a2;
    logic [7:0] v;
    do_write(8'h9E, 8'hA5, a1, a2);
    chk("R2 address ack", a1, 1);
    chk("R3 data ack", a2, 1);
    chk("R3 code after write", dac_code, 8'hA5);
    do_read(8'h9F, a1, v);
    chk("R6 read ack", a1, 1);
    chk("R6 read value", v, 8'hA5);
    do_read(8'h9D, a1, v);
    chk("R6 read with y=0", v, 8'hA5);
  endtask

  task automatic t_bounds();
    logic a1, a2;
    logic [7:0] v;
    do_write(8'h9E, 8'hFF, a1, a2);
    chk("R3 code 0xFF", dac_code, 8'hFF);
    do_read(8'h9F, a1, v);
    chk("R6 read 0xFF", v, 8'hFF);
    do_write(8'h9C, 8'h01, a1, a2);
    chk("R3 code 0x00", dac_code, 8'h00);
    do_read(8'h9F, a1, v);
    chk("R6 read 0x00", v, 8'h00);
  endtask

  task automatic t_protect_low();
    logic a1, a2;
    logic [7:0] v;
    int p0;
    wp = 1'b0; tick(4);
    p0 = prog_cnt;
    do_write(8'h9E, 8'h55, a1, a2);
    chk("R5 addr ack wp low", a1, 1);
    chk("R5 data ack wp low", a2, 1);
    chk("R5 code unchanged", dac_code, 8'h00);
    do_write(8'h9C, 8'h54, a1, a2);
    chk("R5 no store request", prog_cnt - p0, 0);
    do_read(8'h9F, a1, v);
    chk("R6 read wp low", v, 8'h00);
    wp = 1'b1; tick(4);
  endtask

  task automatic t_store();
    logic a1, a2;
    int p0;
    do_write(8'h9C, 8'h5B, a1, a2);
    chk("R3 code 0x5A", dac_code, 8'h5A);
    p0 = prog_cnt;
    do_write(8'h9E, 8'h00, a1, a2);
    chk("R4 data ack", a2, 1);
    chk("R4 one store pulse", prog_cnt - p0, 1);
    chk("R4 code kept", dac_code, 8'h5A);
  endtask

  task automatic t_extra_byte();
    logic a1, a2, a3;
    bus_start();
    send_byte(8'h9C, a1);
    send_byte(8'h43, a2);
    chk("R3 code 0x42 before stop", dac_code, 8'h42);
    send_byte(8'hFF, a3);
    bus_stop();
    chk("R8 third byte nack", a3, 0);
    chk("R8 code unchanged", dac_code, 8'h42);
  endtask

  task automatic t_multi_read();
    logic a1;
    logic [7:0] v1, v2;
    bus_start();
    send_byte(8'h9F, a1);
    read_byte(1'b1, v1);
    read_byte(1'b0, v2);
    chk("R7 first byte", v1, 8'h42);
    chk("R7 repeated byte", v2, 8'h42);
    tick(QP);
    chk("R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic a1, a2;
    bus_start();
    send_byte(8'hA0, a1);
    send_byte(8'h00, a2);
    bus_stop();
    chk("R2 mismatch nack", a1, 0);
    chk("R2 released after mismatch", a2, 0);
    do_write(8'h8E, 8'h11, a1, a2);
    chk("R2 near-miss nack", a1, 0);
    chk("R2 code unchanged", dac_code, 8'h42);
  endtask

  task automatic t_restart();
    logic a1, a2;
    logic [7:0] v;
    bus_start();
    send_byte(8'h9E, a1);
    bus_start();
    send_byte(8'h9F, a2);
    read_byte(1'b0, v);
    bus_stop();
    chk("R9 restart addr ack", a2, 1);
    chk("R9 read after restart", v, 8'h42);
    chk("R9 code unchanged", dac_code, 8'h42);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_write_basic();
    t_bounds();
    t_protect_low();
    t_store();
    t_extra_byte();
    t_multi_read();
    t_bad_addr();
    t_restart();
    tick(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule